// File: doc/BRIEF.md
# Dual-Mode Event and Gate-Width Counter

This block serves a pair of already-filtered digital inputs with one unsigned counter each. A channel in event mode counts the low-to-high transitions on its input. A bus-cycle strobe copies the event counts into snapshot registers, which the host reads. It can also be asked to run in gate mode. The gate-mode channel then becomes a pulse-width timer. While its input is high it counts ticks of a reference clock, and the tick rate is picked by a code. The count stops at all-ones rather than wrapping. When the input falls, the count is committed to a result register.

The reference ticks come from a binary prescaler. The prescaler runs on a base enable pulse that the surrounding logic supplies at the highest reference rate, for example one pulse per 48 MHz period. Select code k divides that rate by 2^k. Codes above MAX_SHIFT act as MAX_SHIFT.

Only one channel can own the timer at a time. A request from a second channel is refused, and a conflict bit reports the refusal. After each measurement there is a recovery window, and a new gate is not accepted until it ends.

Gate results leave the block on a valid/ready output. The gate pulse on the pin cannot be stalled, so back-pressure does not hold up the timer. Instead, a result that has not been accepted is replaced by the next one. `res_valid` stays high with stable data until `res_ready` is seen high at a clock edge.

Top module: `dual_gate_counter`

## Requirements
- R1: After reset, every snapshot is 0, `res_valid` is 0, `gate_owner` is 0 and `mode_conflict` is 0.
- R2: A channel in event mode adds one to its count for each 0-to-1 transition of its input. An input that stays high adds nothing more.
- R3: When `snap_strobe` is high at an edge, every channel's snapshot takes its count, including a transition counted at that same edge. Between strobes the snapshot does not change.
- R4: The event count wraps from all-ones to 0. With CNT_W bits, 2^CNT_W transitions leave the snapshot at its earlier value.
- R5: In gate mode, a rising input starts a measurement from 0. Each reference tick while the input is high adds one. At the falling edge the count goes to `res_data`, the owner's index goes to `res_chan`, and `res_valid` is set.
- R6: A gate count that reaches all-ones stays at all-ones until the commit.
- R7: Reference ticks come on base-enable pulses only. With select code k (codes above MAX_SHIFT use MAX_SHIFT), a pulse is a tick when the number of base pulses before it since reset, taken mod 2^k, equals 2^k-1.
- R8: `gate_owner` is one-hot or zero. A current owner keeps the timer while it still requests it. Otherwise the lowest-index requester gets it. `mode_conflict` is high one cycle after two or more channels request at once.
- R9: A rising gate input seen within RECOVERY clock cycles after a commit is ignored, and that pulse produces no result.
- R10: `res_valid` with `res_data` stays until a clock edge with `res_ready` high. A newer commit replaces a result that has not been accepted.
- R11: A channel does not count event transitions while it owns the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_en | input | 1 | One-cycle pulse at the fastest reference rate |
| clk_sel | input | SEL_W | Reference divide code, rate = base / 2^code |
| mode_req | input | NCH | Per-channel request for gate mode |
| evt_in | input | NCH | Filtered channel inputs (event or gate) |
| snap_strobe | input | 1 | Bus-cycle strobe that captures event counts |
| evt_snap | output | NCH*CNT_W | Snapshot counts, channel i at bits i*CNT_W |
| gate_owner | output | NCH | One-hot channel that owns the timer |
| mode_conflict | output | 1 | A gate request was refused |
| res_valid | output | 1 | Gate result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | CNT_W | Measured gate width in reference ticks |
| res_chan | output | IDX_W | Channel that produced the result |

## Verification
The hardest situation to reach is a gate rising during the recovery window. It only shows up if the input is raised a few cycles after a commit, with ticks inside that pulse, and then the result stream is checked for a value that must never appear. The bench runs a short measurement and raises the gate three cycles after the commit. It checks that no result appears. It then waits out the window and checks that the next measurement arrives as the next scoreboard item. For saturation and wrap, the bench narrows the counter so that all-ones is reached within the run.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  typedef enum logic [1:0] {
    GT_IDLE = 2'd0,
    GT_MEAS = 2'd1,
    GT_REST = 2'd2
  } gt_state_e;
endpackage

// File: rtl/dgc_ref_tick.sv
module dgc_ref_tick #(
  parameter int SEL_W     = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [MAX_SHIFT-1:0] pre_q;
  logic [MAX_SHIFT-1:0] mask;

  // low k bits of the mask set, k clamped at MAX_SHIFT
  always_comb begin
    mask = '0;
    for (int i = 0; i < MAX_SHIFT; i++)
      if (i < int'(sel)) mask[i] = 1'b1;
  end

  assign tick = base_en && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (base_en) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/dgc_event_chan.sv
module dgc_event_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             hold,
  input  logic             strobe,
  output logic [CNT_W-1:0] snap
);
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             inc;

  assign inc   = evt && !prev_q && !hold;
  assign cnt_d = inc ? cnt_q + 1'b1 : cnt_q;   // wraps naturally

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      snap   <= '0;
    end else begin
      prev_q <= evt;
      cnt_q  <= cnt_d;
      if (strobe) snap <= cnt_d;
    end
  end
endmodule

// File: rtl/dgc_mode_arb.sv
module dgc_mode_arb #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] mode_req,
  output logic [NCH-1:0] owner_oh,
  output logic           conflict
);
  logic [NCH-1:0] nxt;
  logic           keep;
  logic           found;

  always_comb begin
    keep  = |(owner_oh & mode_req);
    nxt   = '0;
    found = 1'b0;
    if (keep) begin
      nxt = owner_oh;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (mode_req[i] && !found) begin
          nxt[i] = 1'b1;
          found  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_oh <= '0;
      conflict <= 1'b0;
    end else begin
      owner_oh <= nxt;
      conflict <= |(mode_req & ~nxt);
    end
  end
endmodule

// File: rtl/dgc_gate_timer.sv
module dgc_gate_timer
  import dgc_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int CNT_W    = 16,
  parameter int RECOVERY = 20001,
  localparam int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int REC_W   = $clog2(RECOVERY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   evt,
  input  logic [NCH-1:0]   owner_oh,
  input  logic             tick,
  output logic             commit,
  output logic [CNT_W-1:0] commit_val,
  output logic [IDX_W-1:0] commit_chan,
  output logic             meas,
  output logic             rest
);
  gt_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REC_W-1:0] rec_q;
  logic [NCH-1:0]   own_q;
  logic             prev_q;
  logic             gate;
  logic             chg;
  logic             rise;
  logic             fall;
  logic [IDX_W-1:0] idx;

  assign gate = |(evt & owner_oh);
  assign chg  = (owner_oh != own_q);
  assign rise = gate && !prev_q && !chg;
  assign fall = !gate && prev_q && !chg;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++)
      if (owner_oh[i]) idx = IDX_W'(i);
  end

  assign meas        = (state_q == GT_MEAS);
  assign rest        = (state_q == GT_REST);
  assign commit      = meas && fall;
  assign commit_val  = cnt_q;
  assign commit_chan = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GT_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      own_q   <= '0;
      prev_q  <= 1'b0;
    end else begin
      own_q  <= owner_oh;
      prev_q <= gate;
      if (chg && state_q == GT_MEAS) begin
        state_q <= GT_IDLE;                 // owner left: drop measurement
      end else begin
        unique case (state_q)
          GT_IDLE: if (rise && |owner_oh) begin
            state_q <= GT_MEAS;
            cnt_q   <= '0;
          end
          GT_MEAS: if (fall) begin
            state_q <= GT_REST;
            rec_q   <= REC_W'(RECOVERY - 1);
          end else if (tick && cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
          end
          GT_REST: if (rec_q == '0) state_q <= GT_IDLE;
                   else             rec_q   <= rec_q - 1'b1;
          default: state_q <= GT_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_gate_counter.sv
module dual_gate_counter #(
  parameter int NCH       = 2,
  parameter int CNT_W     = 16,
  parameter int SEL_W     = 4,
  parameter int MAX_SHIFT = 8,
  parameter int RECOVERY  = 20001,
  localparam int IDX_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_en,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic [NCH-1:0]     mode_req,
  input  logic [NCH-1:0]     evt_in,
  input  logic               snap_strobe,
  output logic [NCH*CNT_W-1:0] evt_snap,
  output logic [NCH-1:0]     gate_owner,
  output logic               mode_conflict,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [CNT_W-1:0]   res_data,
  output logic [IDX_W-1:0]   res_chan
);
  logic             tick;
  logic [NCH-1:0]   owner_oh;
  logic             commit;
  logic [CNT_W-1:0] commit_val;
  logic [IDX_W-1:0] commit_chan;
  logic             gt_meas;
  logic             gt_rest;

  dgc_ref_tick #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_tick (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .sel(clk_sel), .tick(tick)
  );

  dgc_mode_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
    .owner_oh(owner_oh), .conflict(mode_conflict)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dgc_event_chan #(.CNT_W(CNT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .evt(evt_in[g]), .hold(owner_oh[g]),
      .strobe(snap_strobe), .snap(evt_snap[g*CNT_W +: CNT_W])
    );
  end

  dgc_gate_timer #(.NCH(NCH), .CNT_W(CNT_W), .RECOVERY(RECOVERY)) u_gate (
    .clk(clk), .rst_n(rst_n), .evt(evt_in), .owner_oh(owner_oh), .tick(tick),
    .commit(commit), .commit_val(commit_val), .commit_chan(commit_chan),
    .meas(gt_meas), .rest(gt_rest)
  );

  assign gate_owner = owner_oh;

  // result stage: newer commit overwrites an unaccepted one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else if (commit) begin
      res_valid <= 1'b1;
      res_data  <= commit_val;
      res_chan  <= commit_chan;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dgc_checker.sv
module dgc_checker #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   mode_req,
  input logic [NCH-1:0]   owner_oh,
  input logic             mode_conflict,
  input logic             gt_meas,
  input logic             gt_rest,
  input logic [CNT_W-1:0] gate_cnt,
  input logic             commit,
  input logic             res_valid,
  input logic             res_ready,
  input logic [CNT_W-1:0] res_data
);
  a_r8_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_oh));

  a_r8_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mode_req) > 1) |=> mode_conflict);

  a_r6_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (gt_meas && gate_cnt == {CNT_W{1'b1}}) |=> (!gt_meas || gate_cnt == {CNT_W{1'b1}}));

  a_r9_no_start_in_rest: assert property (@(posedge clk) disable iff (!rst_n)
    gt_rest |=> !gt_meas);

  a_r5_commit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> res_valid);

  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !commit) |=> (res_valid && $stable(res_data)));
endmodule

bind dual_gate_counter dgc_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_dgc_checker (
  .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .owner_oh(owner_oh),
  .mode_conflict(mode_conflict), .gt_meas(gt_meas), .gt_rest(gt_rest),
  .gate_cnt(u_gate.cnt_q), .commit(commit), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/test_dual_gate_counter.sv
`timescale 1ns/1ps
module test_dual_gate_counter;
  localparam int NCH = 2, CNT_W = 10, SEL_W = 4, MAX_SHIFT = 8, RECOVERY = 8;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, base_en = 0, snap_strobe = 0, res_ready = 1;
  logic [SEL_W-1:0] clk_sel = '0;
  logic [NCH-1:0] mode_req = '0, evt_in = '0, gate_owner;
  logic [NCH*CNT_W-1:0] evt_snap;
  logic mode_conflict, res_valid;
  logic [CNT_W-1:0] res_data;
  logic res_chan;

  int total = 0, fails = 0, pulses = 0;
  int exp_evt[NCH];
  int q_val[$];
  int q_ch[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_gate_counter #(.NCH(NCH), .CNT_W(CNT_W), .SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT),
    .RECOVERY(RECOVERY)) i_dual_gate_counter (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .clk_sel(clk_sel), .mode_req(mode_req),
    .evt_in(evt_in), .snap_strobe(snap_strobe), .evt_snap(evt_snap), .gate_owner(gate_owner),
    .mode_conflict(mode_conflict), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_chan(res_chan));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int snap_of(int ch);
    return int'(evt_snap[ch*CNT_W +: CNT_W]);
  endfunction

  // scoreboard monitor: samples just before each rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && res_valid && res_ready) begin
      if (q_val.size() == 0) begin
        chk("R5 unexpected result", int'(res_data), -1);
      end else begin
        chk("R5 result value", int'(res_data), q_val.pop_front());
        chk("R5 result channel", int'(res_chan), q_ch.pop_front());
      end
    end
  end

  task automatic pulse_evt(int ch, bit counted);
    @(negedge clk) evt_in[ch] = 1'b1;
    @(negedge clk) evt_in[ch] = 1'b0;
    if (counted) exp_evt[ch] = (exp_evt[ch] + 1) & MAXV;
  endtask

  task automatic strobe_check(string tag);
    @(negedge clk) snap_strobe = 1'b1;
    @(negedge clk) snap_strobe = 1'b0;
    for (int c = 0; c < NCH; c++) chk(tag, snap_of(c), exp_evt[c]);
  endtask

  // gate pulse with n base pulses inside; expected from R7 tick rule
  task automatic measure(int ch, int n, bit expect_result);
    int k, m, ticks;
    k = (int'(clk_sel) > MAX_SHIFT) ? MAX_SHIFT : int'(clk_sel);
    m = (1 << k) - 1;
    ticks = 0;
    @(negedge clk) evt_in[ch] = 1'b1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if ((pulses & m) == m) ticks++;
      pulses++;
      base_en = 1'b1;
      @(negedge clk);
    end
    base_en = 1'b0;
    if (expect_result) begin
      q_val.push_back(ticks > MAXV ? MAXV : ticks);
      q_ch.push_back(ch);
    end
    evt_in[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_evt[c] = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 snap0", snap_of(0), 0);
    chk("R1 snap1", snap_of(1), 0);
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 owner", int'(gate_owner), 0);
    chk("R1 conflict", int'(mode_conflict), 0);

    // R2 rising edges only; a long high level counts once
    for (int i = 0; i < 3; i++) pulse_evt(0, 1);
    for (int i = 0; i < 5; i++) pulse_evt(1, 1);
    @(negedge clk) evt_in[0] = 1'b1;
    idle(4);
    evt_in[0] = 1'b0;
    exp_evt[0]++;
    strobe_check("R2 edge count");

    // R3 edge in strobe cycle is included, snapshot holds between strobes
    @(negedge clk) begin evt_in[1] = 1'b1; snap_strobe = 1'b1; end
    @(negedge clk) begin evt_in[1] = 1'b0; snap_strobe = 1'b0; end
    exp_evt[1]++;
    chk("R3 same-cycle edge", snap_of(1), exp_evt[1]);
    pulse_evt(1, 1);
    pulse_evt(1, 1);
    chk("R3 snapshot holds", snap_of(1), exp_evt[1] - 2);
    strobe_check("R3 later strobe");

    // R8 ownership and refusal
    mode_req = 2'b01;
    idle(2);
    chk("R8 owner ch0", int'(gate_owner), 1);
    chk("R8 no conflict", int'(mode_conflict), 0);
    mode_req = 2'b11;
    idle(2);
    chk("R8 second refused", int'(gate_owner), 1);
    chk("R8 conflict flag", int'(mode_conflict), 1);

    // R5 and R7 gate widths at several divide codes
    clk_sel = 4'd0; measure(0, 5, 1);   idle(RECOVERY + 4);
    clk_sel = 4'd2; measure(0, 10, 1);  idle(RECOVERY + 4);
    clk_sel = 4'd9; measure(0, 300, 1); idle(RECOVERY + 4);
    clk_sel = 4'd0; measure(0, 0, 1);   idle(RECOVERY + 4);

    // R11 owner channel's events not counted
    strobe_check("R11 owner holds count");

    // R9 rise inside recovery ignored
    measure(0, 3, 1);
    idle(1);
    measure(0, 4, 0);
    idle(3);
    chk("R9 early gate ignored", int'(res_valid), 0);
    idle(RECOVERY + 4);
    measure(0, 2, 1);
    idle(RECOVERY + 4);

    // R6 saturation
    measure(0, MAXV + 77, 1);
    idle(RECOVERY + 4);

    // R10 back-pressure and overwrite
    @(negedge clk) res_ready = 1'b0;
    measure(0, 2, 0);
    idle(RECOVERY + 4);
    chk("R10 held while not ready", int'(res_valid), 1);
    chk("R10 first value held", int'(res_data), 2);
    measure(0, 6, 1);
    idle(3);
    chk("R10 overwritten", int'(res_data), 6);
    @(negedge clk) res_ready = 1'b1;
    idle(RECOVERY + 4);

    // R8 hand-over to ch1 and measurement on it
    mode_req = 2'b10;
    idle(2);
    chk("R8 owner ch1", int'(gate_owner), 2);
    chk("R8 conflict cleared", int'(mode_conflict), 0);
    measure(1, 4, 1);
    idle(RECOVERY + 4);

    // R4 wrap over 2^CNT_W edges
    mode_req = 2'b00;
    idle(2);
    for (int i = 0; i < (1 << CNT_W); i++) pulse_evt(0, 1);
    strobe_check("R4 wrap");

    idle(5);
    chk("R5 scoreboard drained", q_val.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule